// File: doc/BRIEF.md
# H-Bridge Gate Control and Fault Supervisor

This block is the digital core of a full-bridge DC motor driver. Two asynchronous direction inputs are synchronised and decoded into four gate enables: one high-side and one low-side switch per output leg. A per-leg interlock with a programmable dead time makes sure the two switches of a leg are never on together, and that one is off for a set interval before the other turns on.

The block also supervises the bridge. It takes digital comparator outputs for a high-side output short, low-side overcurrent, a short across the load, open-load sensing, overtemperature, and the two supply thresholds. Each current or load fault must persist for a parameterised number of clock cycles before it counts. A confirmed fault switches off the whole bridge and pulls the active-low error flag low. A fault clears when the direction command changes. The exception is a load short, which stays latched until reset or until the supply drops out and returns. Undervoltage and overtemperature do not latch. Each has its own hysteresis pair of inputs, and while either condition lasts the bridge is held off and the flag is low.

Top module: `hbridge_ctrl`

## Requirements
- R1: With `{cmd_a_i,cmd_b_i}` = 00, the gates `{gate_hs1_o,gate_ls1_o,gate_hs2_o,gate_ls2_o}` settle to 1001 (forward). With 01 they settle to 0110 (reverse), with 10 to 0101 (brake, both low sides), and with 11 to 0000 (high impedance). A command takes two synchroniser stages plus the gate register to reach the gates.
- R2: The high-side and low-side gates of one leg are never high in the same cycle. When a leg hands over from one switch to the other, the gap with both gates low is exactly DEAD_CYC+1 cycles.
- R3: A fault input (high-side short, low-side overcurrent, load short, open-load) is confirmed only after it has been high for QUAL_CYC consecutive cycles. A shorter pulse has no effect, and the count starts again from zero.
- R4: A confirmed fault forces all four gates low and drives `err_n_o` low, and both stay that way after the fault input drops.
- R5: Open-load is evaluated only in the high-impedance command (11), as `ol_out1_hi_i` and `ol_out2_lo_i` both high. In any other command these inputs have no effect.
- R6: Any change of the synchronised command clears a latched high-side short, low-side overcurrent or open-load fault. It releases `err_n_o` and restarts every qualification count.
- R7: A latched load short survives command changes. It is cleared only by reset or by a period of undervoltage.
- R8: `sup_low_i` high locks the bridge off and drives `err_n_o` low. The lockout is released only once `sup_ok_i` is high. While both inputs are low, the previous state holds.
- R9: `temp_hot_i` high turns all gates off and drives `err_n_o` low. This state holds until `temp_cool_i` is high.
- R10: After reset all gates are low and `err_n_o` is low, because the supply is treated as not yet good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_a_i | input | 1 | Direction command bit A (asynchronous) |
| cmd_b_i | input | 1 | Direction command bit B (asynchronous) |
| hs_short_i | input | 1 | High-side output shorted to ground comparator |
| ls_oc_i | input | 1 | Low-side overcurrent / short to supply comparator |
| load_short_i | input | 1 | Short across the load comparator |
| ol_out1_hi_i | input | 1 | Output 1 sensed pulled high |
| ol_out2_lo_i | input | 1 | Output 2 sensed pulled low |
| temp_hot_i | input | 1 | Overtemperature trip |
| temp_cool_i | input | 1 | Temperature back below release point |
| sup_ok_i | input | 1 | Supply above switch-on threshold |
| sup_low_i | input | 1 | Supply below switch-off threshold |
| gate_hs1_o | output | 1 | Leg 1 high-side gate enable |
| gate_ls1_o | output | 1 | Leg 1 low-side gate enable |
| gate_hs2_o | output | 1 | Leg 2 high-side gate enable |
| gate_ls2_o | output | 1 | Leg 2 low-side gate enable |
| err_n_o | output | 1 | Active-low error flag (drive-low enable) |

## Verification
A dead-time counter stuck at the wrong value shows within one handover as a changed gap between the falling and rising gates of a leg. A stuck interlock shows as an overlap on the very cycle it happens. An off-by-one in a qualification counter shows as a fault confirmed by a pulse one cycle short of QUAL_CYC, or as the flag held high after exactly QUAL_CYC cycles. The fault and lockout latches are wrong in two ways: the flag fails to drop within two cycles of the cause, or it fails to return once the command changes or the release input arrives. A load-short latch that clears too easily shows the first time the command changes after such a short.

// File: rtl/hb_pkg.sv
package hb_pkg;
  // Direction command encoding {a,b}
  typedef enum logic [1:0] {
    CMD_FWD = 2'b00,
    CMD_REV = 2'b01,
    CMD_BRK = 2'b10,
    CMD_OFF = 2'b11
  } hb_cmd_e;

  // Fault qualification channels
  localparam int unsigned FLT_HS   = 0;
  localparam int unsigned FLT_LS   = 1;
  localparam int unsigned FLT_LOAD = 2;
  localparam int unsigned FLT_OPEN = 3;
  localparam int unsigned NFLT     = 4;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st1_q, st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= RST_VAL;
      st2_q <= RST_VAL;
    end else begin
      st1_q <= d_i;
      st2_q <= st1_q;
    end
  end

  assign q_o = st2_q;
endmodule

// File: rtl/hb_qual.sv
module hb_qual #(
  parameter int unsigned QUAL_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic restart_i,
  output logic conf_o
);
  localparam int unsigned CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run;

  assign run    = cond_i && !restart_i;
  assign conf_o = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = '0;
    if (run) cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (QUAL_CYC > 1) begin : g_chk
      // R3: confirmation needs the condition in the previous cycle too
      p_no_instant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conf_o |-> $past(cond_i && !restart_i));
    end
  endgenerate
endmodule

// File: rtl/hb_leg.sv
module hb_leg #(
  parameter int unsigned DEAD_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_hs_i,
  input  logic req_ls_i,
  output logic gate_hs_o,
  output logic gate_ls_o
);
  localparam int unsigned DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DLOAD = DW'(DEAD_CYC);

  logic          hs_q, ls_q, hs_d, ls_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic          idle;

  assign idle = (dcnt_q == '0);

  always_comb begin
    // a switch may turn on only with the partner off and the dead time spent
    hs_d = req_hs_i && !req_ls_i && (hs_q || (!ls_q && idle));
    ls_d = req_ls_i && !req_hs_i && (ls_q || (!hs_q && idle));
    if ((hs_q && !hs_d) || (ls_q && !ls_d)) dcnt_d = DLOAD;
    else if (!idle)                         dcnt_d = dcnt_q - 1'b1;
    else                                    dcnt_d = dcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      dcnt_q <= '0;
    end else begin
      hs_q   <= hs_d;
      ls_q   <= ls_d;
      dcnt_q <= dcnt_d;
    end
  end

  assign gate_hs_o = hs_q;
  assign gate_ls_o = ls_q;

  // R2: no shoot-through, and no direct handover between switches
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs_o && gate_ls_o));
  p_hs_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hs_o) |-> !$past(gate_ls_o));
  p_ls_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_ls_o) |-> !$past(gate_hs_o));
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned QUAL_CYC = 2500,
  parameter int unsigned DEAD_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_a_i,
  input  logic cmd_b_i,
  input  logic hs_short_i,
  input  logic ls_oc_i,
  input  logic load_short_i,
  input  logic ol_out1_hi_i,
  input  logic ol_out2_lo_i,
  input  logic temp_hot_i,
  input  logic temp_cool_i,
  input  logic sup_ok_i,
  input  logic sup_low_i,
  output logic gate_hs1_o,
  output logic gate_ls1_o,
  output logic gate_hs2_o,
  output logic gate_ls2_o,
  output logic err_n_o
);
  logic [1:0]      cmd_s, cmd_q;
  logic            cmd_chg;
  logic [NFLT-1:0] cond, conf;
  logic            flt_q, flt_d, lsh_q, lsh_d, uv_q, uv_d, ot_q, ot_d;
  logic            kill;
  logic            rq_hs1, rq_ls1, rq_hs2, rq_ls2;

  hb_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cmd_a_i, cmd_b_i}), .q_o(cmd_s));

  assign cmd_chg = (cmd_s != cmd_q);

  assign cond[FLT_HS]   = hs_short_i;
  assign cond[FLT_LS]   = ls_oc_i;
  assign cond[FLT_LOAD] = load_short_i;
  assign cond[FLT_OPEN] = (cmd_s == CMD_OFF) && ol_out1_hi_i && ol_out2_lo_i;

  for (genvar gi = 0; gi < NFLT; gi++) begin : g_qual
    hb_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n), .cond_i(cond[gi]),
      .restart_i(cmd_chg), .conf_o(conf[gi]));
  end

  always_comb begin
    flt_d = flt_q;
    if (cmd_chg) flt_d = 1'b0;
    if (conf[FLT_HS] || conf[FLT_LS] || conf[FLT_OPEN]) flt_d = 1'b1;
    lsh_d = lsh_q;
    if (conf[FLT_LOAD]) lsh_d = 1'b1;
    if (uv_q)           lsh_d = 1'b0;
    uv_d = uv_q;
    if (sup_ok_i)  uv_d = 1'b0;
    if (sup_low_i) uv_d = 1'b1;
    ot_d = ot_q;
    if (temp_cool_i) ot_d = 1'b0;
    if (temp_hot_i)  ot_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 2'b11;
      flt_q <= 1'b0;
      lsh_q <= 1'b0;
      uv_q  <= 1'b1;
      ot_q  <= 1'b0;
    end else begin
      cmd_q <= cmd_s;
      flt_q <= flt_d;
      lsh_q <= lsh_d;
      uv_q  <= uv_d;
      ot_q  <= ot_d;
    end
  end

  assign kill = flt_q || lsh_q || uv_q || ot_q;

  always_comb begin
    rq_hs1 = 1'b0; rq_ls1 = 1'b0; rq_hs2 = 1'b0; rq_ls2 = 1'b0;
    if (!kill) begin
      unique case (hb_cmd_e'(cmd_s))
        CMD_FWD: begin rq_hs1 = 1'b1; rq_ls2 = 1'b1; end
        CMD_REV: begin rq_ls1 = 1'b1; rq_hs2 = 1'b1; end
        CMD_BRK: begin rq_ls1 = 1'b1; rq_ls2 = 1'b1; end
        default: ;
      endcase
    end
  end

  hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg1 (
    .clk(clk), .rst_n(rst_n), .req_hs_i(rq_hs1), .req_ls_i(rq_ls1),
    .gate_hs_o(gate_hs1_o), .gate_ls_o(gate_ls1_o));
  hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg2 (
    .clk(clk), .rst_n(rst_n), .req_hs_i(rq_hs2), .req_ls_i(rq_ls2),
    .gate_hs_o(gate_hs2_o), .gate_ls_o(gate_ls2_o));

  assign err_n_o = !kill;

  // R4: any shutdown cause empties the bridge on the next edge
  p_kill_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !(gate_hs1_o || gate_ls1_o || gate_hs2_o || gate_ls2_o));
  // R7: a load short holds while the supply stays good
  p_load_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lsh_q && !uv_q) |=> lsh_q);
  // R8: supply drop reaches the gates two edges later
  p_uv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sup_low_i |-> ##2 !(gate_hs1_o || gate_ls1_o || gate_hs2_o || gate_ls2_o));
  // R9: overtemperature pulls the flag on the next cycle
  p_ot_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    temp_hot_i |=> !err_n_o);
endmodule

// File: tb/hbridge_ctrl_tb_top.sv
module hbridge_ctrl_tb_top;
  localparam int unsigned QUAL = 16;
  localparam int unsigned DEAD = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_a, cmd_b, hs_sh, ls_oc, ld_sh, ol_hi, ol_lo, t_hot, t_cool, s_ok, s_low;
  logic g_hs1, g_ls1, g_hs2, g_ls2, err_n;

  int checks = 0;
  int fails  = 0;
  int overlap = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  hbridge_ctrl #(.QUAL_CYC(QUAL), .DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_a_i(cmd_a), .cmd_b_i(cmd_b),
    .hs_short_i(hs_sh), .ls_oc_i(ls_oc), .load_short_i(ld_sh),
    .ol_out1_hi_i(ol_hi), .ol_out2_lo_i(ol_lo), .temp_hot_i(t_hot),
    .temp_cool_i(t_cool), .sup_ok_i(s_ok), .sup_low_i(s_low),
    .gate_hs1_o(g_hs1), .gate_ls1_o(g_ls1), .gate_hs2_o(g_hs2),
    .gate_ls2_o(g_ls2), .err_n_o(err_n));

  // R2 overlap watch
  always @(negedge clk)
    if (rst_n && ((g_hs1 && g_ls1) || (g_hs2 && g_ls2))) overlap++;

  // monitor: pops expectations and compares
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      @(negedge clk);
      begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({g_hs1, g_ls1, g_hs2, g_ls2, err_n} !== e) begin
          fails++;
          $display("FAIL %s: gates/err actual %b expected %b", t,
                   {g_hs1, g_ls1, g_hs2, g_ls2, err_n}, e);
        end
      end
    end
  end

  task automatic expect_st(input logic [3:0] g, input logic e, input string t);
    exp_q.push_back({g, e});
    tag_q.push_back(t);
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmd(input logic [1:0] c);
    {cmd_a, cmd_b} = c;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int ls_idx, hs_idx;
    rst_n = 1'b0; {cmd_a, cmd_b} = 2'b11;
    hs_sh = 0; ls_oc = 0; ld_sh = 0; ol_hi = 0; ol_lo = 0;
    t_hot = 0; t_cool = 0; s_ok = 0; s_low = 0;
    step(3);
    rst_n = 1'b1;
    step(2);
    expect_st(4'b0000, 1'b0, "R10 reset state");
    s_ok = 1'b1; step(3);
    expect_st(4'b0000, 1'b1, "R8 supply good, high impedance");

    set_cmd(2'b00); step(12); expect_st(4'b1001, 1'b1, "R1 forward");
    set_cmd(2'b01); step(12); expect_st(4'b0110, 1'b1, "R1 reverse");
    set_cmd(2'b10); step(12); expect_st(4'b0101, 1'b1, "R1 brake");
    set_cmd(2'b11); step(12); expect_st(4'b0000, 1'b1, "R1 high impedance");
    set_cmd(2'b10); step(12);

    // R2 dead-time gap on leg 1 brake -> forward
    set_cmd(2'b00);
    ls_idx = -1; hs_idx = -1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (ls_idx < 0 && !g_ls1) ls_idx = i;
      if (hs_idx < 0 && g_hs1)  hs_idx = i;
    end
    checks++;
    if (ls_idx < 0 || hs_idx < 0 || (hs_idx - ls_idx) != DEAD + 1) begin
      fails++;
      $display("FAIL R2 dead gap: actual %0d expected %0d", hs_idx - ls_idx, DEAD + 1);
    end
    expect_st(4'b1001, 1'b1, "R1 forward after handover");

    // R3 short pulses do not confirm
    hs_sh = 1; step(QUAL - 2); hs_sh = 0; step(1);
    hs_sh = 1; step(QUAL - 2); hs_sh = 0; step(3);
    expect_st(4'b1001, 1'b1, "R3 sub-threshold pulses ignored");
    // R4 confirmed and latched
    hs_sh = 1; step(QUAL + 4); hs_sh = 0; step(5);
    expect_st(4'b0000, 1'b0, "R4 high-side short latched");
    set_cmd(2'b01); step(14);
    expect_st(4'b0110, 1'b1, "R6 command change clears fault");

    ls_oc = 1; step(QUAL + 4); ls_oc = 0; step(5);
    expect_st(4'b0000, 1'b0, "R4 low-side overcurrent latched");
    set_cmd(2'b10); step(14);
    expect_st(4'b0101, 1'b1, "R6 clear after overcurrent");

    // R5 open-load
    set_cmd(2'b00); step(12);
    ol_hi = 1; ol_lo = 1; step(QUAL + 10);
    expect_st(4'b1001, 1'b1, "R5 open-load ignored while driving");
    set_cmd(2'b11); step(QUAL + 10);
    expect_st(4'b0000, 1'b0, "R5 open-load latched in off state");
    ol_hi = 0; ol_lo = 0;
    set_cmd(2'b00); step(14);
    expect_st(4'b1001, 1'b1, "R6 clear after open-load");

    // R7 load short
    ld_sh = 1; step(QUAL + 4); ld_sh = 0; step(3);
    expect_st(4'b0000, 1'b0, "R7 load short latched");
    set_cmd(2'b01); step(14);
    expect_st(4'b0000, 1'b0, "R7 command change does not clear load short");
    s_ok = 0; s_low = 1; step(3); s_low = 0; s_ok = 1; step(12);
    expect_st(4'b0110, 1'b1, "R7 undervoltage cycle clears load short");

    // R8 hysteresis
    s_ok = 0; s_low = 1; step(3);
    expect_st(4'b0000, 1'b0, "R8 lockout on supply low");
    s_low = 0; step(10);
    expect_st(4'b0000, 1'b0, "R8 held between thresholds");
    s_ok = 1; step(12);
    expect_st(4'b0110, 1'b1, "R8 release on supply ok");

    // R9 overtemperature
    t_hot = 1; step(2); t_hot = 0; step(1);
    expect_st(4'b0000, 1'b0, "R9 overtemperature off");
    step(10);
    expect_st(4'b0000, 1'b0, "R9 held until cool");
    t_cool = 1; step(1); t_cool = 0; step(12);
    expect_st(4'b0110, 1'b1, "R9 resume after cool");

    checks++;
    if (overlap != 0) begin
      fails++;
      $display("FAIL R2 overlap cycles: actual %0d expected 0", overlap);
    end
    summary();
    $finish;
  end
endmodule